// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog for a processor subsystem. Software programs a reload value and turns the counter on through a control register. From then on it must write a fixed 16-bit key to a restart register before the counter reaches zero. If the counter runs out, the block drives a reset pulse on an output pin. The pulse width is programmable, and so are its polarity and its pin drive style. The counter can decrement once per system clock, or once per microsecond using a prescaled tick.

Writes to the control register are accepted only when they flip the enable bit. Polarity and drive style change only when a write carries one of four 8-bit keys in the top byte. A memory controller that is busy resetting can veto an expiry through an input. The block then clears its control register and drives no pulse. When system reset is not selected in the control register, an expiry only raises a flag. That flag stays set until the next valid restart.

The register interface uses 32-bit, word-aligned accesses. Read data is combinational on the address.

Top module: `kwdog`

## Requirements
- R1: After reset, the counter (byte offset 0x00) and the reload register (0x04) both read 0x03EF1480. The control register (0x0C) reads 0 and the width register (0x18) reads 0x000000FF. The pin is idle, and with the reset default (active low, open drain) that means output enable is 0. The expired flag is 0.
- R2: The reload register and the mask register (0x1C) store a full 32-bit write. The restart register (0x08) always reads 0. A write to the counter offset is ignored. Any unmapped offset (for example 0x10) reads 0.
- R3: A write to 0x08 whose low 16 bits are 0x4755 copies the reload value into the counter and, if enable is set, starts counting. Any other value leaves the counter unchanged.
- R4: Control bit 0 is enable. A write to 0x0C is stored whole (bits 5:0; bits 31:6 read 0) only when it changes bit 0. On 0→1 the counter is loaded from reload and starts. On 1→0 counting stops and the counter holds its value. A write that leaves bit 0 unchanged has no effect.
- R5: With control bit 4 set, the counter decrements once per PRESCALE clock cycles. With bit 4 clear, it decrements on every clock cycle.
- R6: A running counter that is already 0 when a decrement is due expires on that edge, and counting stops. If control bit 1 is set, the pulse starts on that same edge and lasts the stored width in microsecond ticks, with a minimum of one tick.
- R7: On a write to 0x18, bits 19:0 are always stored as the width. Top byte 0xA5 sets bit 31 (active high) and 0x5A clears it. Top byte 0xA8 sets bit 30 (push-pull) and 0x8A clears it. Any other top byte leaves bits 31:30 unchanged.
- R8: In push-pull mode, output enable is 1 and the output is the active level during a pulse and the inverse otherwise. In open-drain mode, the output is 0 and output enable is 1 exactly when the level to present is low.
- R9: If the memory-reset input is high when an expiry occurs, the control register becomes 0, no pulse is driven and the expired flag stays 0.
- R10: If control bit 1 is clear, an expiry sets the expired flag and drives no pulse. A write with the wrong key leaves the flag set. The next restart with the correct key clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| mem_rst_busy | input | 1 | Memory controller reset in progress; vetoes expiry |
| wdt_expired | output | 1 | Expired without a system reset request |
| rst_pin_o | output | 1 | Reset pin output value |
| rst_pin_oe | output | 1 | Reset pin output enable |

## Verification
The hardest situation to reach from the ports is the exact expiry edge. It only counts if the counter has been at zero for a full tick, and a control or restart write in that same cycle takes priority. The stimulus loads a small reload value in per-clock mode and counts edges from the enabling write. It then checks that the counter reads zero with the pin still idle, and that the pulse appears one edge later. In microsecond mode and for pulse widths, the prescaler phase is not visible at the ports, so those checks bound the cycle count between the smallest and largest value that phase allows.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
   localparam logic [7:0] OFF_COUNT = 8'h00;
   localparam logic [7:0] OFF_LOAD  = 8'h04;
   localparam logic [7:0] OFF_KICK  = 8'h08;
   localparam logic [7:0] OFF_CTRL  = 8'h0C;
   localparam logic [7:0] OFF_WIDTH = 8'h18;
   localparam logic [7:0] OFF_MASK  = 8'h1C;

   localparam logic [15:0] KICK_KEY = 16'h4755;
   localparam logic [7:0]  KEY_POL_HIGH = 8'hA5;
   localparam logic [7:0]  KEY_POL_LOW  = 8'h5A;
   localparam logic [7:0]  KEY_DRV_PP   = 8'hA8;
   localparam logic [7:0]  KEY_DRV_OD   = 8'h8A;

   localparam int CTRL_W    = 6;
   localparam int CB_EN     = 0;
   localparam int CB_SYSRST = 1;
   localparam int CB_USCLK  = 4;

   localparam logic [31:0] COUNT_RST = 32'h03EF1480;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_COUNT, SEL_LOAD, SEL_KICK, SEL_CTRL, SEL_WIDTH, SEL_MASK
   } reg_sel_e;
endpackage

// File: rtl/kwdog_tick.sv
module kwdog_tick #(
   parameter int PRESCALE = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (PRESCALE < 1) begin : g_bad
         $error("kwdog_tick: PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PH_LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] ph;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ph <= '0;
            else if (ph == PH_LAST)  ph <= '0;
            else                     ph <= ph + 1'b1;
         end
         assign tick_o = (ph == PH_LAST);

         // R5: ticks are never back to back when dividing
         a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/kwdog_count.sv
module kwdog_count
   import kwdog_pkg::*;
#(
   parameter int          CNT_W   = 32,
   parameter logic [31:0] LOAD_RST = COUNT_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              load_we,
   input  logic              ctrl_we,
   input  logic              kick_we,
   input  logic [31:0]       wdata,
   input  logic              mem_rst_busy,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  load_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              expired_o,
   output logic              fire_o
);
   generate
      if (CNT_W < 16 || CNT_W > 32) begin : g_bad
         $error("kwdog_count: CNT_W must lie in 16..32");
      end
   endgenerate

   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(LOAD_RST);

   logic [CNT_W-1:0]  count_q, load_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              run_q, expired_q;
   logic              kick_ok, ctrl_chg, step, hit;

   assign kick_ok  = kick_we && (wdata[15:0] == KICK_KEY);
   assign ctrl_chg = ctrl_we && (wdata[CB_EN] != ctrl_q[CB_EN]);
   assign step     = ctrl_q[CB_USCLK] ? us_tick : 1'b1;
   assign hit      = run_q && step && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= RST_VAL;
         load_q    <= RST_VAL;
         ctrl_q    <= '0;
         run_q     <= 1'b0;
         expired_q <= 1'b0;
      end else begin
         if (load_we) load_q <= wdata[CNT_W-1:0];
         if (kick_ok) begin
            count_q   <= load_q;
            run_q     <= ctrl_q[CB_EN];
            expired_q <= 1'b0;
         end else if (ctrl_chg) begin
            ctrl_q <= wdata[CTRL_W-1:0];
            run_q  <= wdata[CB_EN];
            if (wdata[CB_EN]) count_q <= load_q;
         end else if (run_q && step) begin
            if (count_q == '0) begin
               run_q <= 1'b0;
               if (mem_rst_busy)            ctrl_q    <= '0;
               else if (!ctrl_q[CB_SYSRST]) expired_q <= 1'b1;
            end else begin
               count_q <= count_q - 1'b1;
            end
         end
      end
   end

   assign fire_o    = hit && !kick_ok && !ctrl_chg && !mem_rst_busy && ctrl_q[CB_SYSRST];
   assign count_o   = count_q;
   assign load_o    = load_q;
   assign ctrl_o    = ctrl_q;
   assign expired_o = expired_q;

   // R3: a keyed restart reloads the counter
   a_r3_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
      kick_ok |=> count_q == $past(load_q));
   // R4: control writes that keep the enable bit are dropped
   a_r4_same_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !kick_ok && wdata[CB_EN] == ctrl_q[CB_EN]) |=> $stable(ctrl_q));
   // R6: an expiry stops the counter
   a_r6_expiry_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !kick_ok && !ctrl_chg) |=> !run_q);
   // R9: memory-reset veto clears control
   a_r9_veto_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mem_rst_busy && !kick_ok && !ctrl_chg) |=> ctrl_q == '0);
   // R10: the flag only rises when no system reset was selected
   a_r10_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired_q) |-> !ctrl_q[CB_SYSRST]);
endmodule

// File: rtl/kwdog_pulse.sv
module kwdog_pulse #(
   parameter int PW_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            us_tick,
   input  logic            fire,
   input  logic [PW_W-1:0] width,
   input  logic            act_high,
   input  logic            push_pull,
   output logic            pin_o,
   output logic            pin_oe
);
   logic [PW_W-1:0] rem_q;
   logic            active, level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rem_q <= '0;
      else if (fire)                   rem_q <= (width == '0) ? PW_W'(1) : width;
      else if (active && us_tick)      rem_q <= rem_q - 1'b1;
   end

   assign active = (rem_q != '0);
   assign level  = active ? act_high : !act_high;
   assign pin_o  = push_pull ? level : 1'b0;
   assign pin_oe = push_pull ? 1'b1  : !level;

   // R6: a fire request always produces a pulse on the next cycle
   a_r6_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> active);
   // R8: push-pull always drives, open drain never drives high
   a_r8_push_pull_drives: assert property (@(posedge clk) disable iff (!rst_n)
      push_pull |-> pin_oe);
   a_r8_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
      !push_pull |-> !pin_o);
endmodule

// File: rtl/kwdog.sv
module kwdog
   import kwdog_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int CNT_W    = 32,
   parameter int PW_W     = 20,
   parameter int PRESCALE = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              mem_rst_busy,
   output logic              wdt_expired,
   output logic              rst_pin_o,
   output logic              rst_pin_oe
);
   generate
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
         $error("kwdog: ADDR_W must lie in 5..16");
      end
      if (PW_W < 8 || PW_W > 24) begin : g_bad_pw
         $error("kwdog: PW_W must lie in 8..24");
      end
   endgenerate

   localparam int WI_W = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
   localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
   localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFF_KICK);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(OFF_WIDTH);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);

   reg_sel_e        sel;
   logic [WI_W-1:0] widx;

   assign widx = bus_addr[ADDR_W-1:2];

   always_comb begin
      if      (widx == A_COUNT[ADDR_W-1:2]) sel = SEL_COUNT;
      else if (widx == A_LOAD[ADDR_W-1:2])  sel = SEL_LOAD;
      else if (widx == A_KICK[ADDR_W-1:2])  sel = SEL_KICK;
      else if (widx == A_CTRL[ADDR_W-1:2])  sel = SEL_CTRL;
      else if (widx == A_WIDTH[ADDR_W-1:2]) sel = SEL_WIDTH;
      else if (widx == A_MASK[ADDR_W-1:2])  sel = SEL_MASK;
      else                                  sel = SEL_NONE;
   end

   logic              us_tick, fire;
   logic [CNT_W-1:0]  count_v, load_v;
   logic [CTRL_W-1:0] ctrl_v;
   logic [PW_W-1:0]   width_q;
   logic              pol_high_q, push_pull_q;
   logic [31:0]       mask_q;

   kwdog_tick #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(us_tick)
   );

   kwdog_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
      .load_we(bus_we && sel == SEL_LOAD),
      .ctrl_we(bus_we && sel == SEL_CTRL),
      .kick_we(bus_we && sel == SEL_KICK),
      .wdata(bus_wdata), .mem_rst_busy(mem_rst_busy),
      .count_o(count_v), .load_o(load_v), .ctrl_o(ctrl_v),
      .expired_o(wdt_expired), .fire_o(fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q     <= PW_W'(8'hFF);
         pol_high_q  <= 1'b0;
         push_pull_q <= 1'b0;
         mask_q      <= '0;
      end else if (bus_we) begin
         if (sel == SEL_WIDTH) begin
            width_q <= bus_wdata[PW_W-1:0];
            case (bus_wdata[31:24])
               KEY_POL_HIGH: pol_high_q  <= 1'b1;
               KEY_POL_LOW:  pol_high_q  <= 1'b0;
               KEY_DRV_PP:   push_pull_q <= 1'b1;
               KEY_DRV_OD:   push_pull_q <= 1'b0;
               default: ;
            endcase
         end
         if (sel == SEL_MASK) mask_q <= bus_wdata;
      end
   end

   kwdog_pulse #(.PW_W(PW_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .fire(fire),
      .width(width_q), .act_high(pol_high_q), .push_pull(push_pull_q),
      .pin_o(rst_pin_o), .pin_oe(rst_pin_oe)
   );

   always_comb begin
      unique case (sel)
         SEL_COUNT: bus_rdata = 32'(count_v);
         SEL_LOAD:  bus_rdata = 32'(load_v);
         SEL_CTRL:  bus_rdata = 32'(ctrl_v);
         SEL_WIDTH: bus_rdata = {pol_high_q, push_pull_q, (30 - PW_W)'(0), width_q};
         SEL_MASK:  bus_rdata = mask_q;
         default:   bus_rdata = '0;
      endcase
   end

   // R7: an unkeyed width write keeps polarity and drive
   a_r7_unkeyed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_WIDTH && bus_wdata[31:24] != KEY_POL_HIGH &&
       bus_wdata[31:24] != KEY_POL_LOW && bus_wdata[31:24] != KEY_DRV_PP &&
       bus_wdata[31:24] != KEY_DRV_OD) |=> ($stable(pol_high_q) && $stable(push_pull_q)));
   // R2: the restart offset never returns data
   a_r2_kick_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_KICK) |-> bus_rdata == 32'h0);
endmodule

// File: tb/kwdog_test.sv
module kwdog_test;
   localparam int P = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mem_rst_busy = 1'b0;
   logic        wdt_expired, rst_pin_o, rst_pin_oe;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   kwdog #(.PRESCALE(P)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_rst_busy(mem_rst_busy),
      .wdt_expired(wdt_expired), .rst_pin_o(rst_pin_o), .rst_pin_oe(rst_pin_oe)
   );

   typedef struct {
      string       req;
      int          kind;
      logic [31:0] exp;
   } item_t;
   item_t sb_q[$];

   function automatic logic [31:0] observe(int kind);
      case (kind)
         0: return bus_rdata;
         1: return {31'b0, rst_pin_o};
         2: return {31'b0, rst_pin_oe};
         default: return {31'b0, wdt_expired};
      endcase
   endfunction

   // monitor: compares queued expectations just after each falling edge
   initial forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (observe(it.kind) !== it.exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, observe(it.kind), it.exp);
         end
      end
   end

   task automatic push(string req, int kind, logic [31:0] exp);
      item_t it;
      it.req = req; it.kind = kind; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic peek_reg(logic [4:0] a, logic [31:0] exp, string req);
      bus_addr = a;
      push(req, 0, exp);
   endtask

   task automatic rd(logic [4:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      peek_reg(a, exp, req);
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_rng(string req, int act, int lo, int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic read_now(logic [4:0] a, output int v);
      bus_addr = a;
      #1 v = int'(bus_rdata);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v, n;
      cycles(3);
      rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, 32'h03EF1480, "R1 count reset");
      rd(5'h04, 32'h03EF1480, "R1 reload reset");
      rd(5'h0C, 32'h0, "R1 ctrl reset");
      rd(5'h18, 32'h000000FF, "R1 width reset");
      push("R1 pin oe idle", 2, 32'h0);
      push("R1 expired clear", 3, 32'h0);

      // R2 register map
      wr(5'h04, 32'd10);
      rd(5'h04, 32'd10, "R2 reload rw");
      wr(5'h1C, 32'hDEADBEEF);
      rd(5'h1C, 32'hDEADBEEF, "R2 mask rw");
      rd(5'h08, 32'h0, "R2 restart reads 0");
      wr(5'h00, 32'h5);
      rd(5'h00, 32'h03EF1480, "R2 count write ignored");
      wr(5'h10, 32'h1234);
      rd(5'h10, 32'h0, "R2 unmapped reads 0");

      // R7 keyed width writes
      wr(5'h18, 32'hA5000003);
      rd(5'h18, 32'h80000003, "R7 active high key");
      wr(5'h18, 32'hA8000003);
      rd(5'h18, 32'hC0000003, "R7 push-pull key");
      wr(5'h18, 32'h12000004);
      rd(5'h18, 32'hC0000004, "R7 unkeyed keeps bits");
      wr(5'h18, 32'hA5FFF002);
      rd(5'h18, 32'hC00FF002, "R7 width low 20 bits");
      wr(5'h18, 32'hA5000002);
      // R8 push-pull idle, active high
      @(negedge clk);
      push("R8 pp idle oe", 2, 32'h1);
      push("R8 pp idle level", 1, 32'h0);

      // R3 keyed restart
      wr(5'h08, 32'h00001234);
      rd(5'h00, 32'h03EF1480, "R3 wrong key ignored");
      wr(5'h08, 32'h00FF4755);
      rd(5'h00, 32'd10, "R3 key loads count");

      // R4 / R5 / R6 exact expiry timing, per-clock mode
      wr(5'h0C, 32'h3);
      peek_reg(5'h00, 32'd10, "R4 enable reloads");
      cycles(10);
      peek_reg(5'h00, 32'd0, "R5 per-clock decrement");
      push("R6 no pulse before expiry", 1, 32'h0);
      cycles(1);
      push("R6 pulse on expiry", 1, 32'h1);
      push("R10 no flag with sysrst", 3, 32'h0);
      #1 n = 1;
      while (rst_pin_o && n < 200) begin
         @(negedge clk); #1;
         if (rst_pin_o) n++;
      end
      chk_rng("R6 pulse width 2 ticks", n, P + 1, 2 * P);
      rd(5'h0C, 32'h3, "R4 ctrl stored");
      wr(5'h0C, 32'h13);
      rd(5'h0C, 32'h3, "R4 same enable ignored");

      // R4 disable holds count
      wr(5'h08, 32'h4755);
      cycles(3);
      peek_reg(5'h00, 32'd7, "R3 restart runs when enabled");
      wr(5'h0C, 32'h2);
      cycles(5);
      peek_reg(5'h00, 32'd6, "R4 disable holds count");

      // R5 microsecond mode
      wr(5'h0C, 32'h13);
      cycles(4);
      read_now(5'h00, v);
      chk_rng("R5 us mode slow start", v, 9, 10);
      cycles(100);
      read_now(5'h00, v);
      chk_rng("R5 us mode rate", v, 5, 6);
      wr(5'h0C, 32'h0);

      // R10 flag path
      wr(5'h0C, 32'h1);
      cycles(11);
      push("R10 flag set", 3, 32'h1);
      push("R10 no pulse", 1, 32'h0);
      wr(5'h08, 32'h4756);
      push("R10 wrong key keeps flag", 3, 32'h1);
      wr(5'h08, 32'h4755);
      push("R10 restart clears flag", 3, 32'h0);
      wr(5'h0C, 32'h0);

      // R9 memory reset veto
      mem_rst_busy = 1'b1;
      wr(5'h0C, 32'h3);
      cycles(11);
      peek_reg(5'h0C, 32'h0, "R9 ctrl cleared");
      push("R9 no pulse", 1, 32'h0);
      push("R9 no flag", 3, 32'h0);
      cycles(1);
      mem_rst_busy = 1'b0;

      // R8 open drain, active low, zero width
      wr(5'h18, 32'h5A000000);
      wr(5'h18, 32'h8A000000);
      rd(5'h18, 32'h0, "R7 clear keys");
      wr(5'h04, 32'd3);
      wr(5'h0C, 32'h3);
      cycles(3);
      push("R8 od idle released", 2, 32'h0);
      cycles(1);
      push("R8 od pulse drives", 2, 32'h1);
      push("R8 od drives low", 1, 32'h0);
      #1 n = 1;
      while (rst_pin_oe && n < 200) begin
         @(negedge clk); #1;
         if (rst_pin_oe) n++;
      end
      chk_rng("R6 zero width gives one tick", n, 1, P);

      cycles(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule